// File: doc/BRIEF.md
# Vector Memory Element Address Generator

This block turns one vector memory instruction into a sequence of per-element byte addresses. A single start pulse loads the base address, a signed scalar stride, the data element width, the active length, the first element to generate and the access mode. The block then offers one element at a time on a valid/ready output: the element number, its byte address, the access size and an ordering flag that is passed through unchanged. Four modes are supported: contiguous, constant-stride, indexed (gather/scatter) and bit-packed mask transfer.

In indexed mode the per-element byte offsets arrive on a separate valid/ready stream, along with a code for their width. Each offset is zero-extended and added to the base. Mask-transfer mode derives its own byte count from the active length. All address arithmetic wraps modulo the address width. Elements always come out in ascending order, whether the ordering flag asks for strict order or not. Memory access, translation, data movement and fault handling belong to neighbouring blocks.

Top module: `vec_addr_gen`

## Requirements
- R1: After reset, out_valid, idx_ready and busy are all 0.
- R2: Contiguous mode (mode 0) gives element i the address base + i·2^sew, where sew is coded 0/1/2/3 for 1/2/4/8 bytes. out_size equals sew.
- R3: Strided mode (mode 1) gives element i the address base + i·stride modulo 2^AW. The stride is read as a signed AW-bit value, so a zero stride and a negative stride both work. out_size equals sew.
- R4: Indexed mode (mode 2) gives element i the address base + zext(offset). The offset is the low 8, 16, 32 or 64 bits of idx_data, selected by idx_width coded 0/1/2/3. out_size equals sew whatever the index width.
- R5: Mask mode (mode 3) generates ceil(vl/8) elements at base + i with out_size 0. vstart counts bytes in this mode.
- R6: Generation starts at element vstart, goes up by exactly one per transfer and stops after the last element, at which point busy drops. If vstart is not below the element count, no element is offered and busy stays 0.
- R7: While out_valid is high and out_ready is low, out_valid, out_elem, out_addr and out_size hold their values into the next cycle.
- R8: out_ordered carries the ordered flag captured at start for every element of that operation.
- R9: In indexed mode an element is offered only while idx_valid is high. idx_ready is high only in the cycle in which that element is transferred, so each offset is consumed exactly once.
- R10: A start pulse that arrives while busy is high is ignored. The running operation continues with its own settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Load a new operation (taken only when idle) |
| cfg_mode | input | 2 | 0 contiguous, 1 strided, 2 indexed, 3 mask |
| cfg_ordered | input | 1 | Ordering flag echoed on out_ordered |
| cfg_sew | input | 2 | Data element width code (1/2/4/8 bytes) |
| cfg_base | input | AW | Base byte address |
| cfg_stride | input | AW | Signed byte stride |
| cfg_vl | input | VLW | Active length in elements |
| cfg_vstart | input | VLW | First element (bytes in mask mode) |
| idx_valid | input | 1 | Index offset available |
| idx_ready | output | 1 | Index offset consumed |
| idx_data | input | 64 | Raw index offset |
| idx_width | input | 2 | Index width code (8/16/32/64 bits) |
| out_valid | output | 1 | Element address available |
| out_ready | input | 1 | Consumer accepts the element |
| out_elem | output | VLW | Element number |
| out_addr | output | AW | Element byte address |
| out_size | output | 2 | Access size code (log2 bytes) |
| out_ordered | output | 1 | Ordering flag of the operation |
| busy | output | 1 | Operation in progress |

## Verification
The hold-stability property in indexed mode assumes the index source obeys valid/ready: it keeps idx_data and idx_width steady and idx_valid high until idx_ready. The bench drives offsets this way and changes the offset only after a transfer. The properties also assume that cfg_* is sampled only on an accepted start. The bench changes configuration only together with a start pulse. Stall cycles are inserted on alternate elements, so the hold rule is exercised in every mode.

// File: rtl/vag_pkg.sv
package vag_pkg;
   typedef enum logic [1:0] {
      AM_UNIT   = 2'd0,
      AM_STRIDE = 2'd1,
      AM_INDEX  = 2'd2,
      AM_MASK   = 2'd3
   } am_mode_e;
endpackage

// File: rtl/vag_plan.sv
// Per-operation set-up: element count, address step and first address.
module vag_plan
   import vag_pkg::*;
#(
   parameter int AW  = 32,
   parameter int VLW = 8
) (
   input  am_mode_e         mode,
   input  logic [1:0]       sew,
   input  logic [AW-1:0]    base,
   input  logic [AW-1:0]    stride,
   input  logic [VLW-1:0]   vl,
   input  logic [VLW-1:0]   vstart,
   output logic [VLW-1:0]   count,
   output logic [AW-1:0]    step,
   output logic [AW-1:0]    first,
   output logic             empty
);
   localparam int CW = VLW + 1;

   logic [CW-1:0] vl_plus;
   logic [AW-1:0] vs_ext;

   assign vl_plus = CW'(vl) + CW'(7);
   assign vs_ext  = AW'(vstart);

   always_comb begin
      unique case (mode)
         AM_UNIT:   step = AW'(1) << sew;
         AM_STRIDE: step = stride;
         AM_MASK:   step = AW'(1);
         default:   step = '0;
      endcase
      if (mode == AM_MASK) count = VLW'(vl_plus >> 3);
      else                 count = vl;
   end

   assign first = base + step * vs_ext;
   assign empty = (vstart >= count);
endmodule

// File: rtl/vag_idx_ext.sv
// Selects the index width and zero-extends or truncates to the address width.
module vag_idx_ext #(
   parameter int AW = 32
) (
   input  logic [63:0]   raw,
   input  logic [1:0]    iw,
   output logic [AW-1:0] off
);
   logic [63:0] sel;

   always_comb begin
      unique case (iw)
         2'd0:    sel = {56'd0, raw[7:0]};
         2'd1:    sel = {48'd0, raw[15:0]};
         2'd2:    sel = {32'd0, raw[31:0]};
         default: sel = raw;
      endcase
   end

   generate
      if (AW < 64) begin : g_trunc
         assign off = sel[AW-1:0];
      end else begin : g_full
         assign off = sel;
      end
   endgenerate
endmodule

// File: rtl/vec_addr_gen.sv
module vec_addr_gen
   import vag_pkg::*;
#(
   parameter int AW  = 32,
   parameter int VLW = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [1:0]       cfg_mode,
   input  logic             cfg_ordered,
   input  logic [1:0]       cfg_sew,
   input  logic [AW-1:0]    cfg_base,
   input  logic [AW-1:0]    cfg_stride,
   input  logic [VLW-1:0]   cfg_vl,
   input  logic [VLW-1:0]   cfg_vstart,
   input  logic             idx_valid,
   output logic             idx_ready,
   input  logic [63:0]      idx_data,
   input  logic [1:0]       idx_width,
   output logic             out_valid,
   input  logic             out_ready,
   output logic [VLW-1:0]   out_elem,
   output logic [AW-1:0]    out_addr,
   output logic [1:0]       out_size,
   output logic             out_ordered,
   output logic             busy
);
   generate
      if (AW < 16 || AW > 64) begin : g_bad_aw
         $error("vec_addr_gen: AW must lie in 16..64");
      end
      if (VLW < 1 || VLW >= AW) begin : g_bad_vlw
         $error("vec_addr_gen: VLW must lie in 1..AW-1");
      end
   endgenerate

   am_mode_e       mode_r;
   logic [1:0]     sew_r;
   logic           ord_r;
   logic [AW-1:0]  base_r, step_r, acc_r;
   logic [VLW-1:0] elem_r, count_r;

   logic [VLW-1:0] p_count;
   logic [AW-1:0]  p_step, p_first, idx_off;
   logic           p_empty, fire, last, launch;

   vag_plan #(.AW(AW), .VLW(VLW)) u_plan (
      .mode   (am_mode_e'(cfg_mode)),
      .sew    (cfg_sew),
      .base   (cfg_base),
      .stride (cfg_stride),
      .vl     (cfg_vl),
      .vstart (cfg_vstart),
      .count  (p_count),
      .step   (p_step),
      .first  (p_first),
      .empty  (p_empty)
   );

   vag_idx_ext #(.AW(AW)) u_idx (
      .raw (idx_data),
      .iw  (idx_width),
      .off (idx_off)
   );

   assign launch    = start && !busy && !p_empty;
   assign out_valid = busy && (mode_r != AM_INDEX || idx_valid);
   assign idx_ready = busy && (mode_r == AM_INDEX) && idx_valid && out_ready;
   assign fire      = out_valid && out_ready;
   assign last      = (elem_r == count_r - VLW'(1));

   assign out_elem    = elem_r;
   assign out_addr    = (mode_r == AM_INDEX) ? base_r + idx_off : acc_r;
   assign out_size    = (mode_r == AM_MASK) ? 2'd0 : sew_r;
   assign out_ordered = ord_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         mode_r  <= AM_UNIT;
         sew_r   <= '0;
         ord_r   <= 1'b0;
         base_r  <= '0;
         step_r  <= '0;
         acc_r   <= '0;
         elem_r  <= '0;
         count_r <= '0;
      end else if (launch) begin
         busy    <= 1'b1;
         mode_r  <= am_mode_e'(cfg_mode);
         sew_r   <= cfg_sew;
         ord_r   <= cfg_ordered;
         base_r  <= cfg_base;
         step_r  <= p_step;
         acc_r   <= p_first;
         elem_r  <= cfg_vstart;
         count_r <= p_count;
      end else if (fire) begin
         acc_r  <= acc_r + step_r;
         elem_r <= elem_r + VLW'(1);
         if (last) busy <= 1'b0;
      end
   end

   // R1
   initial_idle_chk: assert property (@(posedge clk) !rst_n |=> !busy);

   // R6
   elem_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> elem_r < count_r);

   // R6
   ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !last) |=> busy && out_elem == $past(out_elem) + VLW'(1));

   // R6
   finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && last) |=> !busy);

   // R7
   hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_addr)
                                   && $stable(out_elem) && $stable(out_size));

   // R2
   unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !last && mode_r == AM_UNIT)
      |=> out_addr == $past(out_addr) + (AW'(1) << out_size));

   // R5
   mask_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && mode_r == AM_MASK) |-> out_size == 2'd0);

   // R10
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start && !fire) |=> busy && $stable(out_elem) && $stable(out_ordered));
endmodule

// File: tb/sim_vec_addr_gen.sv
module sim_vec_addr_gen;
   localparam int AW  = 32;
   localparam int VLW = 8;
   localparam int NV  = 10;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            start = 1'b0;
   logic [1:0]      cfg_mode = '0;
   logic            cfg_ordered = 1'b0;
   logic [1:0]      cfg_sew = '0;
   logic [AW-1:0]   cfg_base = '0;
   logic [AW-1:0]   cfg_stride = '0;
   logic [VLW-1:0]  cfg_vl = '0;
   logic [VLW-1:0]  cfg_vstart = '0;
   logic            idx_valid = 1'b0;
   logic            idx_ready;
   logic [63:0]     idx_data = '0;
   logic [1:0]      idx_width = '0;
   logic            out_valid;
   logic            out_ready = 1'b0;
   logic [VLW-1:0]  out_elem;
   logic [AW-1:0]   out_addr;
   logic [1:0]      out_size;
   logic            out_ordered;
   logic            busy;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   vec_addr_gen #(.AW(AW), .VLW(VLW)) u0 (.*);

   // mode, sew, base, stride, vl, vstart, ordered, idx width, expected element count
   localparam logic [1:0]    T_MODE [NV] = '{0, 0, 1, 1, 1, 2, 2, 2, 3, 3};
   localparam logic [1:0]    T_SEW  [NV] = '{0, 3, 2, 1, 3, 1, 2, 0, 2, 0};
   localparam logic [31:0]   T_BASE [NV] = '{32'h1000, 32'hFFFF_FFF0, 32'h2000, 32'h3000,
                                             32'h0000_0100, 32'h4000, 32'hFFFF_0000,
                                             32'h5000, 32'h6000, 32'h7000};
   localparam logic [31:0]   T_STR  [NV] = '{0, 0, 12, 0, 32'hFFFF_FFF8, 0, 0, 0, 0, 0};
   localparam logic [7:0]    T_VL   [NV] = '{5, 4, 4, 3, 5, 4, 3, 3, 17, 8};
   localparam logic [7:0]    T_VS   [NV] = '{0, 1, 0, 0, 2, 0, 0, 1, 1, 0};
   localparam logic          T_ORD  [NV] = '{0, 0, 1, 0, 0, 1, 0, 1, 0, 1};
   localparam logic [1:0]    T_IW   [NV] = '{0, 0, 0, 0, 0, 0, 3, 1, 0, 0};
   localparam int            T_N    [NV] = '{5, 3, 4, 3, 3, 4, 3, 2, 2, 1};

   function automatic logic [63:0] idx_val(int e);
      return 64'hF0E1_D2C3_B4A5_9687 ^ (64'(e) * 64'h0101_0101_0101_0101);
   endfunction

   function automatic logic [31:0] ref_addr(int v, int e);
      logic [63:0] raw;
      case (T_MODE[v])
         2'd0: return T_BASE[v] + (32'(e) << T_SEW[v]);
         2'd1: return T_BASE[v] + 32'(e) * T_STR[v];
         2'd2: begin
            raw = idx_val(e);
            case (T_IW[v])
               2'd0: raw = raw & 64'hFF;
               2'd1: raw = raw & 64'hFFFF;
               2'd2: raw = raw & 64'hFFFF_FFFF;
               default: ;
            endcase
            return T_BASE[v] + raw[31:0];
         end
         default: return T_BASE[v] + 32'(e);
      endcase
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_vec(int v);
      int cnt;
      logic [31:0] ea;
      logic [1:0]  es;
      @(negedge clk);
      start = 1'b1; cfg_mode = T_MODE[v]; cfg_sew = T_SEW[v]; cfg_base = T_BASE[v];
      cfg_stride = T_STR[v]; cfg_vl = T_VL[v]; cfg_vstart = T_VS[v]; cfg_ordered = T_ORD[v];
      @(negedge clk);
      start = 1'b0;
      cnt = 0;
      for (int e = int'(T_VS[v]); e < int'(T_VS[v]) + T_N[v]; e++) begin
         ea = ref_addr(v, e);
         es = (T_MODE[v] == 2'd3) ? 2'd0 : T_SEW[v];
         idx_valid = (T_MODE[v] == 2'd2); idx_data = idx_val(e); idx_width = T_IW[v];
         out_ready = (e % 2 == 1);
         #1;
         chk(out_valid == 1'b1, "R6 valid", 64'(out_valid), 1);
         chk(out_elem == VLW'(e), "R6 elem", 64'(out_elem), 64'(e));
         chk(out_addr == ea, (T_MODE[v] == 0) ? "R2 addr" : (T_MODE[v] == 1) ? "R3 addr" :
                             (T_MODE[v] == 2) ? "R4 addr" : "R5 addr", 64'(out_addr), 64'(ea));
         chk(out_size == es, "R2 R4 R5 size", 64'(out_size), 64'(es));
         chk(out_ordered == T_ORD[v], "R8 ordered", 64'(out_ordered), 64'(T_ORD[v]));
         if (!out_ready) begin
            @(negedge clk);
            out_ready = 1'b1;
            #1;
            chk(out_valid && out_addr == ea && out_elem == VLW'(e) && out_size == es,
                "R7 hold", 64'(out_addr), 64'(ea));
         end
         chk(idx_ready == (T_MODE[v] == 2'd2), "R9 idx_ready", 64'(idx_ready), 64'(T_MODE[v] == 2'd2));
         @(negedge clk);
         cnt++;
      end
      idx_valid = 1'b0; out_ready = 1'b0;
      #1;
      chk(cnt == T_N[v], "R5 R6 count", 64'(cnt), 64'(T_N[v]));
      chk(!busy && !out_valid, "R6 end", 64'(busy), 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      #1;
      // R1 reset state
      chk(!out_valid && !idx_ready && !busy, "R1 reset", 64'(busy), 0);
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(!out_valid && !busy, "R1 after reset", 64'(busy), 0);

      for (int v = 0; v < NV; v++) run_vec(v);

      // R6 vstart >= vl gives nothing
      @(negedge clk);
      start = 1'b1; cfg_mode = 2'd0; cfg_vl = 8'd3; cfg_vstart = 8'd3; out_ready = 1'b1;
      @(negedge clk); start = 1'b0; #1;
      chk(!busy && !out_valid, "R6 empty", 64'(busy), 0);
      // R5 mask mode vstart in bytes: vl=9 -> 2 bytes, vstart=2 -> empty
      @(negedge clk);
      start = 1'b1; cfg_mode = 2'd3; cfg_vl = 8'd9; cfg_vstart = 8'd2;
      @(negedge clk); start = 1'b0; #1;
      chk(!busy && !out_valid, "R5 mask empty", 64'(busy), 0);
      out_ready = 1'b0;

      // R10 start while busy ignored
      @(negedge clk);
      start = 1'b1; cfg_mode = 2'd0; cfg_sew = 2'd0; cfg_base = 32'hA000; cfg_vl = 8'd2;
      cfg_vstart = 8'd0; cfg_ordered = 1'b0;
      @(negedge clk);
      cfg_base = 32'hB000; cfg_ordered = 1'b1; cfg_vl = 8'd9; // start still high
      @(negedge clk);
      start = 1'b0; #1;
      chk(out_addr == 32'hA000 && out_elem == 0, "R10 addr", 64'(out_addr), 64'hA000);
      chk(out_ordered == 1'b0, "R10 ordered", 64'(out_ordered), 0);
      out_ready = 1'b1;
      @(negedge clk); #1;
      chk(out_addr == 32'hA001, "R10 second", 64'(out_addr), 64'hA001);
      @(negedge clk); #1;
      chk(!busy, "R10 done", 64'(busy), 0);
      out_ready = 1'b0;

      // R9 indexed waits for idx_valid
      @(negedge clk);
      start = 1'b1; cfg_mode = 2'd2; cfg_base = 32'h100; cfg_vl = 8'd1; cfg_vstart = 8'd0;
      @(negedge clk);
      start = 1'b0; out_ready = 1'b1; idx_valid = 1'b0; #1;
      chk(busy && !out_valid && !idx_ready, "R9 wait", 64'(out_valid), 0);
      @(negedge clk);
      idx_valid = 1'b1; idx_data = 64'h20; idx_width = 2'd0; #1;
      chk(out_valid && idx_ready && out_addr == 32'h120, "R9 go", 64'(out_addr), 64'h120);
      @(negedge clk); #1;
      chk(!busy && !out_valid && !idx_ready, "R9 consumed once", 64'(idx_ready), 0);
      idx_valid = 1'b0; out_ready = 1'b0;

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule